// File: doc/BRIEF.md
# ADC Sample FIFO with Formatting

This block sits between an analog-to-digital converter and a host bus. Each time the converter signals that a conversion has finished, the block receives the raw converter code together with two configuration bits that belong to that conversion. One bit marks the conversion as a ghost, to be thrown away. The other chooses unipolar or bipolar output. A conversion that is not a ghost is turned into a 16-bit word and appended to a first-in first-out queue. In unipolar mode the word is plain straight binary. In bipolar mode it is sign-extended two's complement.

The host drains the queue through a read strobe. Each accepted strobe loads the oldest word into a 16-bit data register and removes that word from the queue. Empty, half-full and full flags follow the occupancy. A sticky overflow flag records any non-ghost conversion that was lost because the queue had no free slot. The converter width (12 or 16 bits) and the queue depth (a power of two) are parameters.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset, empty is 1, half_full, full and overflow are 0, and rd_data is 0x0000.
- R2: A conv_done pulse with cfg_ghost high stores nothing and leaves the occupancy unchanged. With cfg_ghost low, exactly one word is stored.
- R3: A read strobe while the queue is not empty loads the oldest stored word into rd_data on the next clock edge and removes it. Words come out in the order they were stored.
- R4: A read strobe while the queue is empty leaves rd_data and all flags unchanged.
- R5: With ADC_BITS=12 and cfg_bipolar=0, the stored word is the 12-bit code with bits 15..12 zero (range 0x0000 to 0x0FFF).
- R6: With ADC_BITS=12 and cfg_bipolar=1, the raw code is offset binary. Bit 11 is inverted and then copied into bits 15..12. Raw 0x000 gives 0xF800, raw 0x800 gives 0x0000, raw 0xFFF gives 0x07FF.
- R7: With ADC_BITS=16, unipolar words equal the code. Bipolar words have bit 15 inverted, so raw 0x0000 gives 0x8000 and raw 0xFFFF gives 0x7FFF.
- R8: empty is 1 exactly when the occupancy is 0, half_full is 1 when the occupancy is at least DEPTH/2, and full is 1 when the occupancy equals DEPTH.
- R9: A non-ghost conversion that arrives while full is high is dropped, even if a read happens in the same cycle. That conversion sets overflow, which then stays at 1 until reset.
- R10: A read strobe and a non-ghost conversion in the same cycle, with the queue neither empty nor full, are both carried out and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | Conversion-complete pulse, one cycle per conversion |
| conv_code | input | ADC_BITS | Raw converter code, offset binary |
| cfg_ghost | input | 1 | Conversion is a ghost and must not be stored |
| cfg_bipolar | input | 1 | 1 selects two's complement, 0 selects straight binary |
| rd_en | input | 1 | Host read strobe; pops the oldest word |
| rd_data | output | 16 | Last word popped from the queue |
| empty | output | 1 | Queue holds no words |
| half_full | output | 1 | Occupancy is at least DEPTH/2 |
| full | output | 1 | Occupancy equals DEPTH |
| overflow | output | 1 | Sticky: a conversion was lost to a full queue |

## Verification
The bench stresses the format edges: bipolar codes at the bottom, the midpoint and the top of the range, in both the 12-bit and the 16-bit build. A formatter that skipped the MSB inversion or the sign extension would return 0x0000 or 0x0800 where 0xF800 is expected. It fills the queue through half-full to full and then adds one more conversion. A design that overwrote the oldest entry or wrapped its pointers would return words out of order and never raise overflow. Ghost conversions are mixed into ordinary traffic, and reads on an empty queue and read-plus-write cycles are included. A design that counted ghosts, moved its pointers on an empty read, or decremented once on a simultaneous access would drift from the model's flags and data.

// File: rtl/adc_fifo_pkg.sv
// Package: shared word type and width for the ADC sample FIFO.
// Assumes host-facing words are always 16 bits wide.
package adc_fifo_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/adc_code_formatter.sv
// Module: converts a raw offset-binary converter code into a 16-bit word.
// Unipolar gives zero-extended straight binary; bipolar inverts the MSB
// and sign-extends. Assumes 1 < ADC_BITS <= 16. Purely combinational.
module adc_code_formatter
    import adc_fifo_pkg::*;
#(
    parameter int ADC_BITS = 12
) (
    input  logic [ADC_BITS-1:0] code,
    input  logic                bipolar,
    output word_t               word
);
    localparam int MSB = ADC_BITS - 1;
    localparam int PAD = WORD_W - ADC_BITS;

    logic [ADC_BITS-1:0] twos;

    // Offset binary to two's complement: flip the top bit only.
    always_comb twos = {~code[MSB], code[MSB-1:0]};

    generate
        if (PAD == 0) begin : g_full_width
            // Word is as wide as the converter: no extension needed.
            always_comb word = bipolar ? twos : code;
        end else begin : g_narrow
            // Zero-extend for unipolar, sign-extend for bipolar.
            always_comb word = bipolar ? {{PAD{twos[MSB]}}, twos}
                                       : {{PAD{1'b0}}, code};
        end
    endgenerate
endmodule

// File: rtl/adc_fifo_ctrl.sv
// Module: pointer, occupancy and flag control for the sample queue.
// A push while full is dropped and sets the sticky overflow flag; a pop
// while empty is ignored. Assumes DEPTH is a power of two, at least 2.
module adc_fifo_ctrl #(
    parameter int DEPTH = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    output logic                       wr_ok,
    output logic                       rd_ok,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       empty,
    output logic                       half_full,
    output logic                       full,
    output logic                       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

    // Qualify the requests against the current occupancy.
    always_comb begin
        wr_ok = push && !full;
        rd_ok = pop && !empty;
    end

    // Advance the write pointer on each accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_addr <= '0;
        else if (wr_ok) wr_addr <= wr_addr + 1'b1;
    end

    // Advance the read pointer on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_addr <= '0;
        else if (rd_ok) rd_addr <= rd_addr + 1'b1;
    end

    // Track occupancy; a simultaneous push and pop cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n)                level <= '0;
        else if (wr_ok && !rd_ok)  level <= level + 1'b1;
        else if (rd_ok && !wr_ok)  level <= level - 1'b1;
    end

    // Latch overflow when a push meets a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)             overflow <= 1'b0;
        else if (push && full)  overflow <= 1'b1;
    end

    // Decode the status flags from the occupancy.
    always_comb begin
        empty     = (level == '0);
        full      = (level == LVL_FULL);
        half_full = (level >= LVL_HALF);
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL);                                     // R8
    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && !empty));                        // R8
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                 // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && overflow));         // R9
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (empty && $stable(rd_addr))); // R4
endmodule

// File: rtl/adc_fifo_store.sv
// Module: queue storage with one write port and a registered read port.
// The output register loads only on an accepted pop and otherwise holds
// its value. Memory contents are not reset; the output register is.
module adc_fifo_store
    import adc_fifo_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  word_t                    wr_word,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output word_t                    rd_word
);
    word_t mem [DEPTH];

    // Write an accepted sample into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    // Load the oldest word on an accepted pop, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_word <= '0;
        else if (rd_en) rd_word <= mem[rd_addr];
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_word));                           // R4
endmodule

// File: rtl/adc_sample_fifo.sv
// Module: top of the ADC sample FIFO. Captures each finished conversion,
// drops ghost conversions, formats the code for the selected mode and
// queues it for the host. Assumes conv_done is a one-cycle pulse per
// conversion, with code and configuration valid in that same cycle.
module adc_sample_fifo
    import adc_fifo_pkg::*;
#(
    parameter int ADC_BITS = 12,
    parameter int DEPTH    = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_done,
    input  logic [ADC_BITS-1:0] conv_code,
    input  logic                cfg_ghost,
    input  logic                cfg_bipolar,
    input  logic                rd_en,
    output logic [15:0]         rd_data,
    output logic                empty,
    output logic                half_full,
    output logic                full,
    output logic                overflow
);
    localparam int AW = $clog2(DEPTH);

    logic          push;
    logic          wr_ok;
    logic          rd_ok;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW:0]   level;
    word_t         fmt_word;

    // Only non-ghost conversions request a slot.
    always_comb push = conv_done && !cfg_ghost;

    adc_code_formatter #(.ADC_BITS(ADC_BITS)) u_fmt (
        .code    (conv_code),
        .bipolar (cfg_bipolar),
        .word    (fmt_word)
    );

    adc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (rd_en),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .level     (level),
        .empty     (empty),
        .half_full (half_full),
        .full      (full),
        .overflow  (overflow)
    );

    adc_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (wr_addr),
        .wr_word (fmt_word),
        .rd_en   (rd_ok),
        .rd_addr (rd_addr),
        .rd_word (rd_data)
    );

    AST_GHOST_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cfg_ghost && !rd_en) |=> $stable(level)); // R2
    AST_RW_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rd_en && !empty && !full) |=> $stable(level)); // R10
    AST_STORE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rd_en && !full) |=> (level == $past(level) + 1'b1)); // R2

    generate
        if (ADC_BITS < WORD_W) begin : g_fmt_checks
            AST_UNIP_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
                (conv_done && !cfg_bipolar) |-> (fmt_word[WORD_W-1:ADC_BITS] == '0)); // R5
            AST_BIP_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
                (conv_done && cfg_bipolar) |->
                ((fmt_word[WORD_W-1:ADC_BITS-1] == '0) ||
                 (&fmt_word[WORD_W-1:ADC_BITS-1])));            // R6
        end
    endgenerate
endmodule

// File: tb/sim_adc_sample_fifo.sv
module sim_adc_sample_fifo;
    localparam int DEPTH = 512;
    localparam int D16   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        conv_done = 0, cfg_ghost = 0, cfg_bipolar = 0, rd_en = 0;
    logic [11:0] conv_code = '0;
    logic [15:0] rd_data;
    logic        empty, half_full, full, overflow;

    logic        b_done = 0, b_ghost = 0, b_bip = 0, b_rd = 0;
    logic [15:0] b_code = '0;
    logic [15:0] b_data;
    logic        b_empty, b_half, b_full, b_ovf;

    adc_sample_fifo #(.ADC_BITS(12), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_code(conv_code),
        .cfg_ghost(cfg_ghost), .cfg_bipolar(cfg_bipolar), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .half_full(half_full), .full(full),
        .overflow(overflow));

    adc_sample_fifo #(.ADC_BITS(16), .DEPTH(D16)) u1 (
        .clk(clk), .rst_n(rst_n), .conv_done(b_done), .conv_code(b_code),
        .cfg_ghost(b_ghost), .cfg_bipolar(b_bip), .rd_en(b_rd),
        .rd_data(b_data), .empty(b_empty), .half_full(b_half), .full(b_full),
        .overflow(b_ovf));

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] mq[$];
    logic [15:0] m_rd = 16'h0000;
    bit          m_ovf = 0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] fmt12(logic [11:0] c, bit bip);
        int v;
        if (!bip) return {4'h0, c};
        v = int'(c) - 2048;
        return v[15:0];
    endfunction

    // Compare every output of u0 with the model.
    task automatic compare_all();
        chk("R3 rd_data", rd_data, m_rd);
        chk("R8 empty", empty, mq.size() == 0);
        chk("R8 half_full", half_full, mq.size() >= DEPTH / 2);
        chk("R8 full", full, mq.size() == DEPTH);
        chk("R9 overflow", overflow, m_ovf);
    endtask

    // One clock of stimulus on u0, with the model stepped alongside.
    task automatic step(bit cv, logic [11:0] code, bit gh, bit bp, bit rd);
        bit was_full;
        conv_done = cv; conv_code = code; cfg_ghost = gh; cfg_bipolar = bp; rd_en = rd;
        was_full = (mq.size() == DEPTH);
        if (rd && mq.size() > 0) m_rd = mq.pop_front();
        if (cv && !gh) begin
            if (was_full) m_ovf = 1;
            else mq.push_back(fmt12(code, bp));
        end
        @(posedge clk);
        @(negedge clk);
        conv_done = 0; rd_en = 0;
        compare_all();
    endtask

    task automatic step16(bit cv, logic [15:0] code, bit bp, bit rd);
        b_done = cv; b_code = code; b_bip = bp; b_rd = rd;
        @(posedge clk);
        @(negedge clk);
        b_done = 0; b_rd = 0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 empty", empty, 1); chk("R1 half_full", half_full, 0);
        chk("R1 full", full, 0);   chk("R1 overflow", overflow, 0);
        chk("R1 rd_data", rd_data, 16'h0000);

        // R5 unipolar with ghosts mixed in (R2)
        step(1, 12'h123, 0, 0, 0);
        step(1, 12'hABC, 1, 0, 0);
        step(1, 12'hFFF, 0, 0, 0);
        step(1, 12'h000, 1, 1, 0);
        step(0, 0, 0, 0, 1); chk("R5 unipolar 0x123", rd_data, 16'h0123);
        step(0, 0, 0, 0, 1); chk("R5 unipolar 0xFFF", rd_data, 16'h0FFF);
        chk("R2 ghosts not stored", empty, 1);

        // R4: read while empty holds data
        hold = rd_data;
        step(0, 0, 0, 0, 1); chk("R4 empty read hold", rd_data, hold);
        chk("R4 still empty", empty, 1);

        // R6: bipolar edges
        step(1, 12'h000, 0, 1, 0);
        step(1, 12'h800, 0, 1, 0);
        step(1, 12'hFFF, 0, 1, 0);
        step(1, 12'h7FF, 0, 1, 0);
        step(0, 0, 0, 0, 1); chk("R6 bip 0x000", rd_data, 16'hF800);
        step(0, 0, 0, 0, 1); chk("R6 bip 0x800", rd_data, 16'h0000);
        // R10: simultaneous read and write
        step(1, 12'h456, 0, 0, 1); chk("R6 bip 0xFFF", rd_data, 16'h07FF);
        step(1, 12'h457, 0, 0, 1); chk("R10 order", rd_data, 16'hFFFF);
        step(0, 0, 0, 0, 1); chk("R10 first kept", rd_data, 16'h0456);
        step(0, 0, 0, 0, 1); chk("R10 second kept", rd_data, 16'h0457);
        chk("R10 drained", empty, 1);

        // R8/R9: fill past full
        for (int i = 0; i < DEPTH; i++) step(1, 12'(i * 7), 0, i[0], 0);
        chk("R8 full reached", full, 1);
        step(1, 12'h321, 0, 0, 0);
        chk("R9 overflow set", overflow, 1);
        step(1, 12'h322, 0, 0, 1);   // full + read: write still dropped
        step(1, 12'h323, 1, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 1);
        chk("R9 overflow sticky", overflow, 1);
        chk("R8 empty after drain", empty, 1);

        // R1: reset clears overflow
        rst_n = 0; mq.delete(); m_rd = 0; m_ovf = 0;
        @(negedge clk); rst_n = 1;
        chk("R1 overflow cleared", overflow, 0);
        chk("R1 rd_data cleared", rd_data, 16'h0000);

        // R7: 16-bit build
        step16(1, 16'h0000, 1, 0);
        step16(1, 16'hFFFF, 1, 0);
        step16(1, 16'h1234, 0, 0);
        step16(1, 16'hFFFF, 0, 0);
        step16(0, 0, 0, 1); chk("R7 bip 0x0000", b_data, 16'h8000);
        step16(0, 0, 0, 1); chk("R7 bip 0xFFFF", b_data, 16'h7FFF);
        step16(0, 0, 0, 1); chk("R7 unip 0x1234", b_data, 16'h1234);
        step16(0, 0, 0, 1); chk("R7 unip 0xFFFF", b_data, 16'hFFFF);
        chk("R7 drained", b_empty, 1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule